// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received Ethernet frames into memory through a ring of buffer descriptors owned alternately by software and hardware. Each descriptor occupies two consecutive 32-bit words: a status/control word and, four bytes above it, the start address of a receive buffer. Software lays out the ring and marks descriptors as owned by hardware. It loads the ring base, then turns the receiver on.

When a frame starts arriving, the engine reads the current descriptor. If hardware owns it, the engine streams the frame bytes into the buffer as word writes with byte enables. It then writes the status word back with the stored length and the error flags and with the ownership bit cleared. Finally it steps to the next descriptor, or back to the ring base when the descriptor carries the wrap mark. If the descriptor is still owned by software, the engine switches the receiver off and discards the frame. It stays off until software turns it on again.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset `rx_en`, `mem_req` and `in_ready` are all low.
- R2: When a frame's first byte is offered while `rx_en` is high, the engine reads the word at the current descriptor address, then the word at that address plus 4 as the buffer address, before it accepts any byte.
- R3: If bit 11 of the fetched status word is 0, the engine clears `rx_en`, accepts and discards the whole frame (through `in_last`), writes nothing to memory, and keeps the same descriptor current for the next frame.
- R4: Frame byte n is written to buffer address (with its two low bits taken as zero) plus n, packed little-endian into 32-bit words (byte n in lane n mod 4). A final partial word enables only the lanes that hold frame bytes. Every request address is word aligned, and no byte is accepted while a memory request is pending.
- R5: The writeback goes to the descriptor's status address with all four byte enables. It carries the stored length in bits 10:0, bit 11 cleared and the fetched wrap bit 12 copied, with bits 31:17 zero.
- R6: The writeback flags sample the error inputs on the last byte: bit 15 from `in_err_crc`, bit 13 from `in_err_align`, bit 16 from `in_err_ovr`.
- R7: A frame longer than MAX_LEN (1540) bytes has only its first MAX_LEN bytes stored. Its length field reads MAX_LEN and bit 14 is set. The surplus bytes are accepted and dropped.
- R8: After a writeback the current descriptor becomes the ring base when the used descriptor's wrap bit is set, and the used address plus 8 otherwise.
- R9: `ctl_en_set` sets `rx_en` and `ctl_en_clr` clears it on the next edge, with set winning when both are asserted. While `rx_en` is low an arriving frame is accepted and discarded with no memory request.
- R10: A pulse on `ring_base_wr` loads `ring_base_val` (low three bits taken as zero) as both the ring base and the current descriptor address.
- R11: A memory request holds its address, direction and data until `mem_gnt` is seen. Read data is taken from the first `mem_rvalid` after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base_wr | input | 1 | Load strobe for the ring base |
| ring_base_val | input | 32 | Ring base byte address |
| ctl_en_set | input | 1 | Turn the receiver on |
| ctl_en_clr | input | 1 | Turn the receiver off |
| rx_en | output | 1 | Receiver enabled |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted when high with in_valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of frame |
| in_err_crc | input | 1 | Frame check failed, valid with in_last |
| in_err_align | input | 1 | Odd bit count, valid with in_last |
| in_err_ovr | input | 1 | Receive overrun, valid with in_last |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
Each descriptor read is requested the cycle after the frame's first byte shows up. A data word write follows the cycle after its fourth byte, or after the last byte. The status writeback follows the cycle after the last data word is granted, but the memory model in the bench stalls grants pseudo-randomly, so none of these is a fixed count of cycles. The scoreboard therefore compares each writeback at the negedge of the cycle in which its grant is seen, and the buffer contents at that same point, since every data write was granted at an earlier edge. Enable changes and dropped frames are checked at the negedge after the registering edge, or once a dropped frame's last byte has gone in. At that point the handshake count and descriptor contents must be unchanged.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int EN_BIT    = 11;
  localparam int WRAP_BIT  = 12;
  localparam int ALIGN_BIT = 13;
  localparam int LONG_BIT  = 14;
  localparam int CRC_BIT   = 15;
  localparam int OVR_BIT   = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_STAT,
    ST_WT_STAT,
    ST_RD_BUF,
    ST_WT_BUF,
    ST_STREAM,
    ST_WR_DATA,
    ST_WR_STAT,
    ST_DROP
  } rxr_state_e;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_val,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] cur
);
  localparam int SH = $clog2(DESC_BYTES);

  logic [AW-1:0] base_q, base_d, cur_q, cur_d;

  always_comb begin
    base_d = base_q;
    cur_d  = cur_q;
    if (base_wr) begin
      base_d = {base_val[AW-1:SH], {SH{1'b0}}};
      cur_d  = {base_val[AW-1:SH], {SH{1'b0}}};
    end else if (adv) begin
      cur_d = wrap ? base_q : cur_q + AW'(DESC_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (base_wr || adv) begin
      base_q <= base_d;
      cur_q  <= cur_d;
    end
  end

  assign cur = cur_q;
endmodule

// File: rtl/rxr_packer.sv
module rxr_packer #(
  parameter int AW = 32,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [AW-1:0]      start_addr,
  input  logic               push,
  input  logic [7:0]         push_byte,
  input  logic               drain,
  output logic [8*LANES-1:0] word,
  output logic [LANES-1:0]   be,
  output logic [AW-1:0]      waddr,
  output logic               lane_last
);
  localparam int LW = $clog2(LANES);
  localparam int DW = 8 * LANES;

  logic [DW-1:0]    word_q, word_d;
  logic [LANES-1:0] be_q, be_d;
  logic [AW-1:0]    waddr_q, waddr_d;
  logic [LW-1:0]    lane_q, lane_d;
  logic             upd;

  always_comb begin
    word_d  = word_q;
    be_d    = be_q;
    waddr_d = waddr_q;
    lane_d  = lane_q;
    if (start) begin
      waddr_d = {start_addr[AW-1:LW], {LW{1'b0}}};
      be_d    = '0;
      lane_d  = '0;
    end else if (push) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_q == LW'(l)) begin
          word_d[8*l +: 8] = push_byte;
          be_d[l]          = 1'b1;
        end
      end
      lane_d = lane_q + 1'b1;
    end else if (drain) begin
      be_d    = '0;
      waddr_d = waddr_q + AW'(LANES);
    end
  end

  assign upd = start | push | drain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      be_q    <= '0;
      waddr_q <= '0;
      lane_q  <= '0;
    end else if (upd) begin
      word_q  <= word_d;
      be_q    <= be_d;
      waddr_q <= waddr_d;
      lane_q  <= lane_d;
    end
  end

  assign word      = word_q;
  assign be        = be_q;
  assign waddr     = waddr_q;
  assign lane_last = (lane_q == LW'(LANES - 1));
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int AW = 32,
  parameter int MAX_LEN = 1540,
  parameter int LEN_W = 11,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_en_set,
  input  logic               ctl_en_clr,
  output logic               rx_en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_last,
  input  logic               in_err_crc,
  input  logic               in_err_align,
  input  logic               in_err_ovr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [LANES-1:0]   mem_be,
  output logic [8*LANES-1:0] mem_wdata,
  input  logic               mem_gnt,
  input  logic [8*LANES-1:0] mem_rdata,
  input  logic               mem_rvalid,
  input  logic [AW-1:0]      cur_ptr,
  input  logic [8*LANES-1:0] pk_word,
  input  logic [LANES-1:0]   pk_be,
  input  logic [AW-1:0]      pk_addr,
  input  logic               pk_lane_last,
  output logic               pk_start,
  output logic               pk_push,
  output logic               pk_drain,
  output logic               ring_adv,
  output logic               ring_wrap,
  output logic               wb_active
);
  localparam int DW = 8 * LANES;

  rxr_state_e       state_q, state_d;
  logic             en_q, en_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;
  logic             done_q, done_d;
  logic             crc_q, crc_d, aln_q, aln_d, ovr_q, ovr_d, long_q, long_d;
  logic             acc, store, hw_clr;
  logic [DW-1:0]    stat_word;

  assign in_ready = (state_q == ST_STREAM) || (state_q == ST_DROP);
  assign acc      = in_valid && in_ready;
  assign store    = (cnt_q < LEN_W'(MAX_LEN));
  assign hw_clr   = (state_q == ST_WT_STAT) && mem_rvalid && !mem_rdata[EN_BIT];

  always_comb begin
    stat_word              = '0;
    stat_word[LEN_W-1:0]   = cnt_q;
    stat_word[WRAP_BIT]    = wrap_q;
    stat_word[ALIGN_BIT]   = aln_q;
    stat_word[LONG_BIT]    = long_q;
    stat_word[CRC_BIT]     = crc_q;
    stat_word[OVR_BIT]     = ovr_q;
  end

  // enable register: engine clear first, software clear, software set wins
  always_comb begin
    en_d = en_q;
    if (hw_clr)     en_d = 1'b0;
    if (ctl_en_clr) en_d = 1'b0;
    if (ctl_en_set) en_d = 1'b1;
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    wrap_d   = wrap_q;
    done_d   = done_q;
    crc_d    = crc_q;
    aln_d    = aln_q;
    ovr_d    = ovr_q;
    long_d   = long_q;
    pk_start = 1'b0;
    pk_push  = 1'b0;
    pk_drain = 1'b0;
    ring_adv = 1'b0;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    mem_be   = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) state_d = en_q ? ST_RD_STAT : ST_DROP;
      end
      ST_RD_STAT: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr;
        if (mem_gnt) state_d = ST_WT_STAT;
      end
      ST_WT_STAT: begin
        if (mem_rvalid) begin
          if (mem_rdata[EN_BIT]) begin
            wrap_d  = mem_rdata[WRAP_BIT];
            state_d = ST_RD_BUF;
          end else begin
            state_d = ST_DROP;
          end
        end
      end
      ST_RD_BUF: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + AW'(4);
        if (mem_gnt) state_d = ST_WT_BUF;
      end
      ST_WT_BUF: begin
        if (mem_rvalid) begin
          pk_start = 1'b1;
          cnt_d    = '0;
          done_d   = 1'b0;
          crc_d    = 1'b0;
          aln_d    = 1'b0;
          ovr_d    = 1'b0;
          long_d   = 1'b0;
          state_d  = ST_STREAM;
        end
      end
      ST_STREAM: begin
        if (acc) begin
          if (store) begin
            pk_push = 1'b1;
            cnt_d   = cnt_q + 1'b1;
          end else begin
            long_d = 1'b1;
          end
          if (in_last) begin
            done_d = 1'b1;
            crc_d  = in_err_crc;
            aln_d  = in_err_align;
            ovr_d  = in_err_ovr;
            state_d = (store || (|pk_be)) ? ST_WR_DATA : ST_WR_STAT;
          end else if (store && pk_lane_last) begin
            state_d = ST_WR_DATA;
          end
        end
      end
      ST_WR_DATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = pk_addr;
        mem_be    = pk_be;
        mem_wdata = pk_word;
        if (mem_gnt) begin
          pk_drain = 1'b1;
          state_d  = done_q ? ST_WR_STAT : ST_STREAM;
        end
      end
      ST_WR_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr;
        mem_be    = '1;
        mem_wdata = stat_word;
        if (mem_gnt) begin
          ring_adv = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (acc && in_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      cnt_q   <= '0;
      wrap_q  <= 1'b0;
      done_q  <= 1'b0;
      crc_q   <= 1'b0;
      aln_q   <= 1'b0;
      ovr_q   <= 1'b0;
      long_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      cnt_q   <= cnt_d;
      wrap_q  <= wrap_d;
      done_q  <= done_d;
      crc_q   <= crc_d;
      aln_q   <= aln_d;
      ovr_q   <= ovr_d;
      long_q  <= long_d;
    end
  end

  assign rx_en     = en_q;
  assign ring_wrap = wrap_q;
  assign wb_active = (state_q == ST_WR_STAT);
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
  parameter int MAX_LEN = 1540,
  parameter int LEN_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ring_base_wr,
  input  logic [31:0] ring_base_val,
  input  logic        ctl_en_set,
  input  logic        ctl_en_clr,
  output logic        rx_en,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_err_crc,
  input  logic        in_err_align,
  input  logic        in_err_ovr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  input  logic        mem_rvalid
);
  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  logic [AW-1:0]    cur_ptr, pk_addr;
  logic [DW-1:0]    pk_word;
  logic [LANES-1:0] pk_be;
  logic             pk_lane_last, pk_start, pk_push, pk_drain;
  logic             ring_adv, ring_wrap, wb_active;

  rxr_ring_ptr #(.AW(AW), .DESC_BYTES(8)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_wr  (ring_base_wr),
    .base_val (ring_base_val),
    .adv      (ring_adv),
    .wrap     (ring_wrap),
    .cur      (cur_ptr)
  );

  rxr_packer #(.AW(AW), .LANES(LANES)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (pk_start),
    .start_addr (mem_rdata),
    .push       (pk_push),
    .push_byte  (in_data),
    .drain      (pk_drain),
    .word       (pk_word),
    .be         (pk_be),
    .waddr      (pk_addr),
    .lane_last  (pk_lane_last)
  );

  rxr_ctrl #(.AW(AW), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .LANES(LANES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_en_set   (ctl_en_set),
    .ctl_en_clr   (ctl_en_clr),
    .rx_en        (rx_en),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_last      (in_last),
    .in_err_crc   (in_err_crc),
    .in_err_align (in_err_align),
    .in_err_ovr   (in_err_ovr),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .mem_wdata    (mem_wdata),
    .mem_gnt      (mem_gnt),
    .mem_rdata    (mem_rdata),
    .mem_rvalid   (mem_rvalid),
    .cur_ptr      (cur_ptr),
    .pk_word      (pk_word),
    .pk_be        (pk_be),
    .pk_addr      (pk_addr),
    .pk_lane_last (pk_lane_last),
    .pk_start     (pk_start),
    .pk_push      (pk_push),
    .pk_drain     (pk_drain),
    .ring_adv     (ring_adv),
    .ring_wrap    (ring_wrap),
    .wb_active    (wb_active)
  );
endmodule

// File: rtl/rx_desc_ring_chk.sv
module rx_desc_ring_chk #(
  parameter int MAX_LEN = 1540
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic        ctl_en_clr,
  input logic        in_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        mem_gnt,
  input logic        mem_rvalid,
  input logic        wb_active
);
  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_no_accept_while_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req);

  assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  assert_wb_returns_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_active && mem_req |-> mem_we && !mem_wdata[11] && mem_be == 4'hF && mem_wdata[31:17] == '0);

  assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_active && mem_req |-> 32'(mem_wdata[10:0]) <= 32'(MAX_LEN));

  assert_en_fall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_en) |-> $past(ctl_en_clr) || $past(mem_rvalid));
endmodule

bind rx_desc_ring rx_desc_ring_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .ctl_en_clr (ctl_en_clr),
  .in_ready   (in_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata),
  .mem_gnt    (mem_gnt),
  .mem_rvalid (mem_rvalid),
  .wb_active  (wb_active)
);

// File: tb/rx_desc_ring_test.sv
module rx_desc_ring_test;
  localparam int MAXL = 1540;
  localparam logic [31:0] DLO = 32'h1000;
  localparam logic [31:0] DHI = 32'h1200;

  logic        clk, rst_n;
  logic        ring_base_wr, ctl_en_set, ctl_en_clr;
  logic [31:0] ring_base_val;
  logic        rx_en, in_valid, in_ready, in_last;
  logic [7:0]  in_data;
  logic        in_err_crc, in_err_align, in_err_ovr;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  rx_desc_ring uut (
    .clk(clk), .rst_n(rst_n), .ring_base_wr(ring_base_wr), .ring_base_val(ring_base_val),
    .ctl_en_set(ctl_en_set), .ctl_en_clr(ctl_en_clr), .rx_en(rx_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_err_crc(in_err_crc), .in_err_align(in_err_align), .in_err_ovr(in_err_ovr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int wb_cnt = 0;
  int hs_cnt = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] daddr;
    logic [31:0] stat;
    logic [31:0] buff;
    int          stored;
    logic [7:0]  seed;
  } exp_t;
  exp_t expq[$];

  logic [7:0] mem [logic [31:0]];

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    logic [31:0] w;
    for (int b = 0; b < 4; b++) begin
      logic [31:0] ab;
      ab = a + 32'(b);
      w[8*b +: 8] = mem.exists(ab) ? mem[ab] : 8'h00;
    end
    return w;
  endfunction

  task automatic wr_word(input logic [31:0] a, input logic [31:0] d);
    for (int b = 0; b < 4; b++) mem[a + 32'(b)] = d[8*b +: 8];
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // memory model: grants stalled by a small LFSR, read data one cycle after grant
  logic [3:0] lfsr;
  logic       gnt_ok;
  assign mem_gnt = mem_req && gnt_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr       <= 4'b1001;
      gnt_ok     <= 1'b0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      lfsr       <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      gnt_ok     <= lfsr[0] | lfsr[1];
      mem_rvalid <= 1'b0;
      if (mem_req && mem_gnt) begin
        hs_cnt = hs_cnt + 1;
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr + 32'(b)] = mem_wdata[8*b +: 8];
        end else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= rd_word(mem_addr);
        end
      end
    end
  end

  // scoreboard monitor: compare each status writeback as it is granted
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_gnt && mem_we && mem_addr >= DLO && mem_addr < DHI) begin
      wb_cnt++;
      if (expq.size() == 0) begin
        chk(1'b0, "R5 unexpected writeback", mem_addr, 32'h0);
      end else begin
        exp_t e;
        int bad;
        e = expq.pop_front();
        chk(mem_addr == e.daddr, "R8 writeback address", mem_addr, e.daddr);
        chk(mem_wdata == e.stat && mem_be == 4'hF, "R5 R6 R7 status word", mem_wdata, e.stat);
        bad = 0;
        for (int i = 0; i < e.stored; i++)
          if (mem[e.buff + 32'(i)] !== e.seed + 8'(i * 7)) bad++;
        chk(bad == 0, "R4 buffer bytes", 32'(bad), 32'h0);
        chk(mem[e.buff + 32'(e.stored)] === 8'hEE, "R4 R7 byte past stored length",
            32'(mem[e.buff + 32'(e.stored)]), 32'hEE);
      end
    end
  end

  // driver: push the expectation, then stream the bytes
  task automatic rx_frame(input int len, input logic [7:0] seed, input bit crc, input bit aln,
                          input bit ovr, input bit expect_store, input logic [31:0] daddr,
                          input logic [31:0] buff, input bit wrap);
    if (expect_store) begin
      exp_t e;
      int stored;
      stored = (len > MAXL) ? MAXL : len;
      for (int i = 0; i < stored + 8; i++) mem[buff + 32'(i)] = 8'hEE;
      e.daddr  = daddr;
      e.buff   = buff;
      e.stored = stored;
      e.seed   = seed;
      e.stat   = 32'(stored) | (32'(wrap) << 12) | (32'(aln) << 13) |
                 (32'(len > MAXL) << 14) | (32'(crc) << 15) | (32'(ovr) << 16);
      expq.push_back(e);
    end
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      in_valid     = 1'b1;
      in_data      = seed + 8'(i * 7);
      in_last      = (i == len - 1);
      in_err_crc   = (i == len - 1) && crc;
      in_err_align = (i == len - 1) && aln;
      in_err_ovr   = (i == len - 1) && ovr;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    in_err_crc = 1'b0; in_err_align = 1'b0; in_err_ovr = 1'b0;
  endtask

  task automatic wait_drain();
    int n;
    n = 0;
    while (expq.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R5 writeback arrived", 32'(expq.size()), 32'h0);
  endtask

  task automatic pulse_set();
    @(negedge clk); ctl_en_set = 1'b1;
    @(negedge clk); ctl_en_set = 1'b0;
  endtask

  task automatic load_base(input logic [31:0] b);
    @(negedge clk); ring_base_wr = 1'b1; ring_base_val = b;
    @(negedge clk); ring_base_wr = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    int hs0, wb0;
    rst_n = 1'b0;
    ring_base_wr = 1'b0; ring_base_val = '0; ctl_en_set = 1'b0; ctl_en_clr = 1'b0;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    in_err_crc = 1'b0; in_err_align = 1'b0; in_err_ovr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rx_en == 1'b0, "R1 rx_en after reset", 32'(rx_en), 32'h0);
    chk(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 32'h0);
    chk(in_ready == 1'b0, "R1 in_ready after reset", 32'(in_ready), 32'h0);

    // ring: bit 11 owner, bit 12 wrap
    wr_word(32'h1000, 32'h0000_0800); wr_word(32'h1004, 32'h2000);
    wr_word(32'h1008, 32'h0000_0800); wr_word(32'h100C, 32'h2800);
    wr_word(32'h1010, 32'h0000_1800); wr_word(32'h1014, 32'h3002);
    load_base(32'h1000);            // R10
    pulse_set();
    chk(rx_en == 1'b1, "R9 set enables", 32'(rx_en), 32'h1);

    // R2 R4 R5 R8 plain frame, word multiple
    rx_frame(60, 8'h01, 0, 0, 0, 1, 32'h1000, 32'h2000, 0);
    wait_drain();
    // R4 partial word, R6 crc flag
    rx_frame(5, 8'h40, 1, 0, 0, 1, 32'h1008, 32'h2800, 0);
    wait_drain();
    // R6 align and overrun, R5 wrap copied, R4 low address bits ignored (0x3002)
    rx_frame(1, 8'h90, 0, 1, 1, 1, 32'h1010, 32'h3000, 1);
    wait_drain();
    // R8 wrap back to base after re-arming descriptor 0
    wr_word(32'h1000, 32'h0000_0800);
    rx_frame(64, 8'h22, 0, 0, 0, 1, 32'h1000, 32'h2000, 0);
    wait_drain();

    // R3 descriptor 1 still owned by software
    hs0 = hs_cnt; wb0 = wb_cnt;
    rx_frame(20, 8'h55, 0, 0, 0, 0, 32'h0, 32'h0, 0);
    repeat (6) @(negedge clk);
    chk(rx_en == 1'b0, "R3 receiver turned off", 32'(rx_en), 32'h0);
    chk(wb_cnt == wb0, "R3 no writeback on refused descriptor", 32'(wb_cnt), 32'(wb0));
    chk(hs_cnt == hs0 + 1, "R3 only the status read", 32'(hs_cnt), 32'(hs0 + 1));
    chk(rd_word(32'h1008) == 32'h0000_8005, "R3 descriptor unchanged",
        rd_word(32'h1008), 32'h0000_8005);

    // R9 frame while disabled: no memory access at all
    hs0 = hs_cnt;
    rx_frame(10, 8'h66, 0, 0, 0, 0, 32'h0, 32'h0, 0);
    repeat (6) @(negedge clk);
    chk(hs_cnt == hs0, "R9 disabled frame makes no request", 32'(hs_cnt), 32'(hs0));

    // R3 pointer kept: re-arm descriptor 1, R7 oversize frame lands there
    wr_word(32'h1008, 32'h0000_0800);
    pulse_set();
    rx_frame(1600, 8'h13, 0, 0, 0, 1, 32'h1008, 32'h2800, 0);
    wait_drain();

    // R9 clear, then set and clear together (set wins)
    @(negedge clk); ctl_en_clr = 1'b1;
    @(negedge clk); ctl_en_clr = 1'b0;
    chk(rx_en == 1'b0, "R9 clear disables", 32'(rx_en), 32'h0);
    ctl_en_clr = 1'b1; ctl_en_set = 1'b1;
    @(negedge clk); ctl_en_clr = 1'b0; ctl_en_set = 1'b0;
    chk(rx_en == 1'b1, "R9 set wins over clear", 32'(rx_en), 32'h1);

    // R10 new ring base of a single wrapping descriptor
    wr_word(32'h1100, 32'h0000_1800); wr_word(32'h1104, 32'h3800);
    load_base(32'h1105);
    rx_frame(33, 8'h77, 0, 0, 0, 1, 32'h1100, 32'h3800, 1);
    wait_drain();
    // R8 wrap returns to the new base
    wr_word(32'h1100, 32'h0000_1800);
    rx_frame(7, 8'hA0, 1, 0, 1, 1, 32'h1100, 32'h3800, 1);
    wait_drain();

    summary();
  end
endmodule